// File: doc/BRIEF.md
# Quarter-Wave Twiddle Factor Generator

This block returns the complex rotation factor W = cos(2πk/N) − j·sin(2πk/N) for a transform index k, and is meant to feed a radix-2 butterfly. The index k comes with a request strobe. One clock later the block presents the real and imaginary parts as registered floating-point words, together with a valid strobe. The transform size N is a parameter and defaults to 1024.

Storage is kept small. The cosine and sine magnitudes are tabulated only for the first quarter period, which is folded index 0 to N/4 inclusive. The real part and the imaginary part each have their own magnitude table. A separate per-index table covers all N indices and holds one sign bit for each part. To serve an index outside the first quadrant, the block mirrors the index into the stored quarter, reads both magnitudes, and attaches the two signs from the sign table. All tables are computed when the design is elaborated.

The word format is sign / 8-bit biased exponent / 23-bit fraction. The biased exponent has bias 127 and the fraction has a hidden leading one. An all-zero word means zero.

Top module: `qtw_twiddle_gen`

## Requirements
- R1: While reset is high, and in the cycle after it is released with no request, `vld_o` is 0 and `re_o` and `im_o` are 32'h0.
- R2: A request accepted at a clock edge gives `vld_o` = 1 after that same edge. When `req_i` is low at an edge, `vld_o` drops to 0 and `re_o` and `im_o` keep their previous values.
- R3: Word format: bit 31 is the sign, bits 30:23 are the exponent with bias 127, and bits 22:0 are the fraction with a hidden one. For every k that is not a multiple of N/4, `re_o` is within one unit in the last place of cos(2πk/N), and `im_o` is within one unit in the last place of −sin(2πk/N). No magnitude field exceeds 31'h3F800000.
- R4: k = 0 gives exactly `re_o` = 32'h3F800000 and `im_o` = 32'h00000000.
- R5: k = N/4 gives exactly `re_o` = 32'h00000000 and `im_o` = 32'hBF800000. k = 3N/4 gives exactly `re_o` = 0 and `im_o` = 32'h3F800000.
- R6: k = N/2 gives exactly `re_o` = 32'hBF800000 and `im_o` = 32'h00000000.
- R7: A zero component is always the all-zero word, with its sign bit clear.
- R8: The sign bit of `re_o` is 1 exactly when N/4 < k < 3N/4. The sign bit of `im_o` is 1 exactly when 0 < k < N/2.
- R9: For 0 < k < N/2, bits 30:0 of `re_o` and of `im_o` are identical for k and for N/2 − k. This is the second-quadrant fold.
- R10: Indices in the lower half-period (N/2 to N−1) meet the same accuracy as R3.
- R11: Requests on consecutive cycles each produce one result, in request order, with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Lookup request strobe |
| k_i | input | log2(N) | Twiddle index k |
| vld_o | output | 1 | Result valid, one cycle after the request |
| re_o | output | 32 | Real part, floating-point word |
| im_o | output | 32 | Imaginary part, floating-point word |

## Verification
The bench sweeps every index of the full period back to back, then sends a gapped, descending set of the four quadrant boundaries.

Each boundary has a specific failure mode. A fold that is off by one at k = N/4 or at 3N/4 would read the wrong end of the quarter table, giving a non-zero real part or a magnitude slightly below one; the exact-word checks catch this. A sign table written with inclusive limits would turn the zero words into negative zeros; the R7/R8 checks catch this.

The bench also compares every k against its mirror N/2 − k. A fold that skipped the second quadrant would still give correct signs but the wrong magnitudes, and this comparison exposes it. The idle-cycle check catches output registers that load without a request.

// File: rtl/qtw_pkg.sv
package qtw_pkg;

    localparam int EXP_W = 8;
    localparam int MAN_W = 23;
    localparam int BIAS  = 127;
    localparam int MAG_W = EXP_W + MAN_W;
    localparam int FP_W  = 1 + MAG_W;
    localparam int SERIES_TERMS = 20;

    localparam real PI = 3.14159265358979323846;

    typedef logic [MAG_W-1:0] mag_t;

    typedef struct packed {
        logic             sgn;
        logic [EXP_W-1:0] ex;
        logic [MAN_W-1:0] fr;
    } fp_t;

    typedef struct packed {
        logic re_neg;
        logic im_neg;
    } sgn_pair_t;

    localparam mag_t MAG_ONE = mag_t'(BIAS) << MAN_W;

    // Power series, accurate well beyond single precision on [0, pi/2].
    function automatic real series_cos(real x);
        real term, sum;
        term = 1.0;
        sum  = 1.0;
        for (int i = 1; i <= SERIES_TERMS; i++) begin
            term = -term * x * x / (real'(2*i-1) * real'(2*i));
            sum  = sum + term;
        end
        return sum;
    endfunction

    function automatic real series_sin(real x);
        real term, sum;
        term = x;
        sum  = x;
        for (int i = 1; i <= SERIES_TERMS; i++) begin
            term = -term * x * x / (real'(2*i) * real'(2*i+1));
            sum  = sum + term;
        end
        return sum;
    endfunction

    // Positive real to exponent/fraction field, round to nearest.
    function automatic mag_t real_to_mag(real v);
        real w;
        int  e;
        int  m;
        if (v <= 0.0) return '0;
        w = v;
        e = 0;
        for (int i = 0; i < 160; i++) begin
            if (w < 1.0) begin
                w = w * 2.0;
                e = e - 1;
            end else if (w >= 2.0) begin
                w = w / 2.0;
                e = e + 1;
            end
        end
        m = $rtoi((w - 1.0) * real'(1 << MAN_W) + 0.5);
        // A rounding carry out of the fraction bumps the exponent.
        return (mag_t'(e + BIAS) << MAN_W) + mag_t'(m);
    endfunction

    // Magnitude at folded index j of an n-point table; endpoints are exact.
    function automatic mag_t table_mag(int j, int n, bit sine);
        real x;
        if (j == 0)     return sine ? '0 : MAG_ONE;
        if (j == n / 4) return sine ? MAG_ONE : '0;
        x = 2.0 * PI * real'(j) / real'(n);
        return real_to_mag(sine ? series_sin(x) : series_cos(x));
    endfunction

    // Sign bits of W at index k; strict limits keep zero components positive.
    function automatic sgn_pair_t sign_of(int k, int n);
        sgn_pair_t s;
        s.re_neg = (k > n / 4) && (k < 3 * n / 4);
        s.im_neg = (k > 0) && (k < n / 2);
        return s;
    endfunction

endpackage

// File: rtl/qtw_fold.sv
module qtw_fold #(
    parameter int N = 1024,
    localparam int KW = $clog2(N),
    localparam int JW = KW - 1
) (
    input  logic [KW-1:0] k_i,
    output logic [JW-1:0] j_o
);
    localparam int RW = KW - 2;
    localparam logic [JW-1:0] QTR = JW'(N / 4);

    logic [1:0]    quad;
    logic [RW-1:0] rem;

    assign quad = k_i[KW-1 -: 2];
    assign rem  = k_i[RW-1:0];

    // Odd quadrants run the quarter wave backwards: j = N/4 - r.
    always_comb begin
        if (quad[0]) j_o = QTR - JW'(rem);
        else         j_o = JW'(rem);
    end
endmodule

// File: rtl/qtw_mag_rom.sv
module qtw_mag_rom import qtw_pkg::*; #(
    parameter int N    = 1024,
    parameter bit SINE = 1'b0,
    localparam int JW    = $clog2(N) - 1,
    localparam int DEPTH = N / 4 + 1
) (
    input  logic [JW-1:0] idx_i,
    output mag_t          mag_o
);
    mag_t tab [DEPTH];

    for (genvar j = 0; j < DEPTH; j++) begin : g_ent
        localparam mag_t VAL = table_mag(j, N, SINE);
        assign tab[j] = VAL;
    end

    assign mag_o = tab[idx_i];
endmodule

// File: rtl/qtw_sign_rom.sv
module qtw_sign_rom import qtw_pkg::*; #(
    parameter int N = 1024,
    localparam int KW = $clog2(N)
) (
    input  logic [KW-1:0] k_i,
    output sgn_pair_t     sgn_o
);
    sgn_pair_t tab [N];

    for (genvar k = 0; k < N; k++) begin : g_ent
        localparam sgn_pair_t VAL = sign_of(k, N);
        assign tab[k] = VAL;
    end

    assign sgn_o = tab[k_i];
endmodule

// File: rtl/qtw_twiddle_gen.sv
module qtw_twiddle_gen import qtw_pkg::*; #(
    parameter int N = 1024,
    localparam int KW = $clog2(N),
    localparam int JW = KW - 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_i,
    input  logic [KW-1:0] k_i,
    output logic          vld_o,
    output logic [FP_W-1:0] re_o,
    output logic [FP_W-1:0] im_o
);
    logic [JW-1:0] fold_idx;
    mag_t          cos_mag;
    mag_t          sin_mag;
    sgn_pair_t     sgn;
    fp_t           re_q;
    fp_t           im_q;

    qtw_fold #(.N(N)) u_fold (
        .k_i (k_i),
        .j_o (fold_idx)
    );

    qtw_mag_rom #(.N(N), .SINE(1'b0)) u_cos_rom (
        .idx_i (fold_idx),
        .mag_o (cos_mag)
    );

    qtw_mag_rom #(.N(N), .SINE(1'b1)) u_sin_rom (
        .idx_i (fold_idx),
        .mag_o (sin_mag)
    );

    qtw_sign_rom #(.N(N)) u_sign_rom (
        .k_i   (k_i),
        .sgn_o (sgn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            re_q  <= '0;
            im_q  <= '0;
        end else begin
            vld_o <= req_i;
            if (req_i) begin
                re_q <= {sgn.re_neg, cos_mag};
                im_q <= {sgn.im_neg, sin_mag};
            end
        end
    end

    assign re_o = re_q;
    assign im_o = im_q;
endmodule

// File: rtl/qtw_twiddle_chk.sv
module qtw_twiddle_chk #(
    parameter int N = 1024,
    localparam int KW = $clog2(N)
) (
    input logic          clk,
    input logic          rst,
    input logic          req_i,
    input logic [KW-1:0] k_i,
    input logic          vld_o,
    input logic [31:0]   re_o,
    input logic [31:0]   im_o
);
    localparam logic [KW-1:0] Q1 = KW'(N / 4);
    localparam logic [KW-1:0] Q2 = KW'(N / 2);
    localparam logic [KW-1:0] Q3 = KW'(3 * N / 4);

    logic want_re_neg;
    logic want_im_neg;
    assign want_re_neg = (k_i > Q1) && (k_i < Q3);
    assign want_im_neg = (k_i != '0) && (k_i < Q2);

    // R2
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        req_i |=> vld_o);
    p_valid_drops_r2: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> !vld_o);
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> ($stable(re_o) && $stable(im_o)));
    // R3
    p_mag_bound_r3: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> (re_o[30:0] <= 31'h3F800000 && im_o[30:0] <= 31'h3F800000));
    // R4
    p_origin_r4: assert property (@(posedge clk) disable iff (rst)
        (req_i && k_i == '0) |=> (re_o == 32'h3F800000 && im_o == 32'h0));
    // R5
    p_quarter_r5: assert property (@(posedge clk) disable iff (rst)
        (req_i && k_i == Q1) |=> (re_o == 32'h0 && im_o == 32'hBF800000));
    // R6
    p_half_r6: assert property (@(posedge clk) disable iff (rst)
        (req_i && k_i == Q2) |=> (re_o == 32'hBF800000 && im_o == 32'h0));
    // R7
    p_pos_zero_r7: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> ((re_o[30:0] != 0 || !re_o[31]) && (im_o[30:0] != 0 || !im_o[31])));
    // R8
    p_sign_r8: assert property (@(posedge clk) disable iff (rst)
        req_i |=> (re_o[31] == $past(want_re_neg) && im_o[31] == $past(want_im_neg)));
endmodule

bind qtw_twiddle_gen qtw_twiddle_chk #(.N(N)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .req_i (req_i),
    .k_i   (k_i),
    .vld_o (vld_o),
    .re_o  (re_o),
    .im_o  (im_o)
);

// File: tb/qtw_twiddle_gen_tb.sv
module qtw_twiddle_gen_tb;
    localparam int N  = 1024;
    localparam int KW = $clog2(N);
    localparam real TWO_PI = 6.28318530717958647692;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_i;
    logic [KW-1:0] k_i;
    logic          vld_o;
    logic [31:0]   re_o;
    logic [31:0]   im_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    typedef struct { int k; int cyc; } item_t;
    item_t q[$];

    logic [31:0] got_re [N];
    logic [31:0] got_im [N];

    qtw_twiddle_gen #(.N(N)) u_dut (
        .clk(clk), .rst(rst), .req_i(req_i), .k_i(k_i),
        .vld_o(vld_o), .re_o(re_o), .im_o(im_o)
    );

    always #2 clk = ~clk;  // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic real decode(input logic [31:0] w);
        real v;
        int  e;
        if (w[30:23] == 0) return 0.0;
        v = 1.0 + real'(w[22:0]) / 8388608.0;
        e = int'(w[30:23]) - 127;
        while (e > 0) begin v = v * 2.0; e--; end
        while (e < 0) begin v = v / 2.0; e++; end
        return w[31] ? -v : v;
    endfunction

    function automatic real ulp_of(input real a);
        real p;
        p = 1.0;
        while (p > a) p = p / 2.0;
        while (p * 2.0 <= a) p = p * 2.0;
        return p / 8388608.0;
    endfunction

    task automatic check_one(input int k);
        real rr, ri, dr, di;
        string tag;
        if (k % (N / 4) == 0) begin
            logic [31:0] er, ei;
            case (k / (N / 4))
                0: begin er = 32'h3F800000; ei = 32'h0;        tag = "R4 k=0"; end
                1: begin er = 32'h0;        ei = 32'hBF800000; tag = "R5 k=N/4"; end
                2: begin er = 32'hBF800000; ei = 32'h0;        tag = "R6 k=N/2"; end
                default: begin er = 32'h0;  ei = 32'h3F800000; tag = "R5 k=3N/4"; end
            endcase
            check(re_o == er, {tag, " re (R7 zero word)"}, re_o, er);
            check(im_o == ei, {tag, " im (R7 zero word)"}, im_o, ei);
        end else begin
            rr = $cos(TWO_PI * real'(k) / real'(N));
            ri = -$sin(TWO_PI * real'(k) / real'(N));
            dr = decode(re_o);
            di = decode(im_o);
            tag = (k >= N / 2) ? "R10" : "R3";
            check((dr - rr <= ulp_of(rr < 0 ? -rr : rr) * 1.0001) && (rr - dr <= ulp_of(rr < 0 ? -rr : rr) * 1.0001),
                  $sformatf("%s re accuracy k=%0d", tag, k), re_o, 32'(k));
            check((di - ri <= ulp_of(ri < 0 ? -ri : ri) * 1.0001) && (ri - di <= ulp_of(ri < 0 ? -ri : ri) * 1.0001),
                  $sformatf("%s im accuracy k=%0d", tag, k), im_o, 32'(k));
            check(re_o[31] == ((k > N / 4) && (k < 3 * N / 4)),
                  $sformatf("R8 re sign k=%0d", k), {31'b0, re_o[31]}, {31'b0, rr < 0.0});
            check(im_o[31] == (k < N / 2),
                  $sformatf("R8 im sign k=%0d", k), {31'b0, im_o[31]}, {31'b0, k < N / 2});
        end
    endtask

    // Monitor: pops one expected item per valid result.
    always @(negedge clk) begin
        if (!rst && vld_o) begin
            if (q.size() == 0) begin
                check(1'b0, "R2 unexpected valid", {31'b0, vld_o}, 32'h0);
            end else begin
                item_t it;
                it = q.pop_front();
                check(cyc == it.cyc + 1, "R11 in-order one-cycle result", 32'(cyc), 32'(it.cyc + 1));
                got_re[it.k] = re_o;
                got_im[it.k] = im_o;
                check_one(it.k);
            end
        end
    end

    task automatic issue(input int kk);
        item_t it;
        req_i = 1'b1;
        k_i   = KW'(kk);
        it.k   = kk;
        it.cyc = cyc;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic idle();
        req_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] cap_re, cap_im;
        rst   = 1'b1;
        req_i = 1'b0;
        k_i   = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(vld_o == 1'b0, "R1 vld in reset", {31'b0, vld_o}, 32'h0);
        check(re_o == 32'h0 && im_o == 32'h0, "R1 data in reset", re_o | im_o, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(vld_o == 1'b0, "R1 vld after release", {31'b0, vld_o}, 32'h0);
        check(re_o == 32'h0 && im_o == 32'h0, "R1 data after release", re_o | im_o, 32'h0);

        // R11 / R3 / R10: full period back to back
        for (int k = 0; k < N; k++) issue(k);
        idle();
        idle();

        // R2: idle cycles leave outputs untouched and valid low
        cap_re = re_o;
        cap_im = im_o;
        for (int i = 0; i < 3; i++) begin
            k_i = KW'(i * 7 + 5);
            idle();
            check(vld_o == 1'b0, "R2 valid low when idle", {31'b0, vld_o}, 32'h0);
            check(re_o == cap_re, "R2 re held when idle", re_o, cap_re);
            check(im_o == cap_im, "R2 im held when idle", im_o, cap_im);
        end

        // Gapped, descending boundaries (R4 R5 R6)
        issue(N - 1); idle();
        issue(3 * N / 4); idle();
        issue(N / 2); idle();
        issue(N / 4 + 1); idle();
        issue(N / 4); idle();
        issue(0); idle();
        idle();
        idle();
        check(q.size() == 0, "R11 every request answered", 32'(q.size()), 32'h0);

        // R9: second-quadrant fold mirrors the first quadrant
        for (int k = 1; k < N / 2; k++) begin
            check(got_re[k][30:0] == got_re[N/2 - k][30:0],
                  $sformatf("R9 re mirror k=%0d", k), got_re[k], got_re[N/2 - k]);
            check(got_im[k][30:0] == got_im[N/2 - k][30:0],
                  $sformatf("R9 im mirror k=%0d", k), got_im[k], got_im[N/2 - k]);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule